// File: doc/BRIEF.md
# Dual-clock presettable up/down counter

This block is a four-bit counter with two separate count-pulse inputs. A rising edge on one input adds one to the count, and a rising edge on the other subtracts one. A parameter picks the counting range. The binary variant runs through 0 to 15. The decade variant runs through 0 to 9 and holds the value in 8421 BCD. An active-low load control copies a four-bit preset value into the count. An active-high clear control forces the count to zero. Load and clear both take effect at once, without waiting for a clock edge, and both override counting.

Two active-low terminal outputs make chaining simple. The carry output goes low while the count is at its top value and the up-pulse input is low. The borrow output goes low while the count is zero and the down-pulse input is low. Each of these outputs returns high in the same cycle that the count wraps. A later stage can therefore take its up and down pulse inputs straight from this stage's carry and borrow outputs.

The pulse inputs are asynchronous to the block. A free-running system clock samples them through a two-flop synchronizer, and the block then detects their rising edges. A count change shows at the output on the third system-clock edge after the pulse input rises. The clear control also returns the synchronizers to their idle-high state.

Top module: `updn_counter`

## Requirements
- R1: A rising edge on `pulse_up` alone adds one to `count`. The new value shows on the third rising edge of `clk` after the input rises.
- R2: A rising edge on `pulse_dn` alone subtracts one from `count`, with the same three-edge latency as R1.
- R3: With DECADE=0 the count runs modulo 16. Counting up from 15 gives 0, and counting down from 0 gives 15.
- R4: With DECADE=1, counting up from 9 gives 0, and counting down from 0 gives 9.
- R5: With DECADE=1, a loaded value from 10 to 15 counts up modulo 16, so 15 goes to 0. Counting down from such a value subtracts one, so 12 goes to 11.
- R6: If both pulse inputs rise together and reach the edge detectors in the same cycle, `count` does not change.
- R7: While `load_n` is 0, `count` equals `preset` without waiting for a `clk` edge, and pulse edges have no effect.
- R8: While `clear` is 1, `count` is 0, and this holds even when `load_n` is also 0. When `clear` is released with both pulse inputs high, no count step follows.
- R9: `carry_n` is 0 exactly while `count` is at its top value (15 binary, 9 decade) and the synchronized `pulse_up` is low. It returns to 1 on the same edge at which the count wraps to 0.
- R10: `borrow_n` is 0 exactly while `count` is 0 and the synchronized `pulse_dn` is low. It returns to 1 on the same edge at which the count wraps to the top value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples the pulse inputs |
| clear | input | 1 | Active-high asynchronous clear of the count and the synchronizers |
| load_n | input | 1 | Active-low asynchronous load of `preset` into the count |
| preset | input | 4 | Parallel preset value |
| pulse_up | input | 1 | Count-up pulse; each rising edge counts up |
| pulse_dn | input | 1 | Count-down pulse; each rising edge counts down |
| count | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal count up, for chaining to the next stage's `pulse_up` |
| borrow_n | output | 1 | Active-low terminal count down, for chaining to the next stage's `pulse_dn` |

## Verification
The bench drives a binary instance and a decade instance side by side from the same inputs. It walks both through the wrap points in each direction, so a design that used the wrong top value would send the decade copy to 10 or the binary copy to 9. It loads the illegal BCD values 14 and 12 and then counts through them. A design that clamped or reset those values would miss the 15-to-0 and 12-to-11 steps. It also checks three more cases:
- Load and clear are checked before any clock edge arrives, which catches a synchronous load or clear.
- Both pulse inputs are raised together, which catches a design that lets one direction win.
- Clear is released while both pulse inputs are high, which catches a synchronizer that resets low and so produces a false edge.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;

  // Highest legal value before wrap
  function automatic cnt_t top_value(input bit decade);
    return decade ? cnt_t'(9) : '1;
  endfunction

  // Next value when counting up; illegal BCD codes simply follow binary order
  function automatic cnt_t step_up(input cnt_t v, input bit decade);
    if (decade && v == cnt_t'(9)) return '0;
    return v + cnt_t'(1);
  endfunction

  // Next value when counting down
  function automatic cnt_t step_down(input cnt_t v, input bit decade);
    if (decade && v == '0) return cnt_t'(9);
    return v - cnt_t'(1);
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clear,
  input  logic pin,
  output logic level,
  output logic rise
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain;

  // Idle state of a pulse input is high, so clear sets the chain to ones
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge clear)
          if (clear) chain[g] <= 1'b1;
          else       chain[g] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or posedge clear)
          if (clear) chain[g] <= 1'b1;
          else       chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign level = chain[STAGES];

  p_rise_single_r1: assert property (@(posedge clk) disable iff (clear)
    rise |=> !rise);
endmodule

// File: rtl/count_core.sv
module count_core
  import updn_pkg::*;
#(
  parameter bit DECADE = 1'b0
) (
  input  logic clk,
  input  logic clear,
  input  logic load_n,
  input  cnt_t preset,
  input  logic inc,
  input  logic dec,
  output cnt_t cnt
);
  cnt_t nxt;

  always_comb begin
    nxt = cnt;
    if (inc && !dec)      nxt = step_up(cnt, DECADE);
    else if (dec && !inc) nxt = step_down(cnt, DECADE);
  end

  always_ff @(posedge clk or posedge clear or negedge load_n)
    if (clear)        cnt <= '0;
    else if (!load_n) cnt <= preset;
    else              cnt <= nxt;

  p_clear_zero_r8: assert property (@(posedge clk)
    $past(clear) && clear |-> cnt == '0);

  p_load_follow_r7: assert property (@(posedge clk) disable iff (clear)
    !load_n && $past(!load_n) && $stable(preset) |-> cnt == preset);

  p_up_step_r1: assert property (@(posedge clk) disable iff (clear)
    load_n && $past(load_n && inc && !dec) |-> cnt == step_up($past(cnt), DECADE));

  p_dn_step_r2: assert property (@(posedge clk) disable iff (clear)
    load_n && $past(load_n && dec && !inc) |-> cnt == step_down($past(cnt), DECADE));

  p_both_hold_r6: assert property (@(posedge clk) disable iff (clear)
    load_n && $past(load_n && (inc == dec)) |-> $stable(cnt));
endmodule

// File: rtl/term_count.sv
module term_count
  import updn_pkg::*;
#(
  parameter bit DECADE = 1'b0
) (
  input  cnt_t cnt,
  input  logic up_level,
  input  logic dn_level,
  output logic carry_n,
  output logic borrow_n
);
  localparam cnt_t TOP = top_value(DECADE);

  assign carry_n  = ~((cnt == TOP) && !up_level);
  assign borrow_n = ~((cnt == '0)  && !dn_level);
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter bit DECADE      = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             load_n,
  input  logic [CNT_W-1:0] preset,
  input  logic             pulse_up,
  input  logic             pulse_dn,
  output logic [CNT_W-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam cnt_t TOP = top_value(DECADE);

  logic up_level, up_rise, dn_level, dn_rise;
  cnt_t cnt;

  edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .clear(clear), .pin(pulse_up), .level(up_level), .rise(up_rise));

  edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .clear(clear), .pin(pulse_dn), .level(dn_level), .rise(dn_rise));

  count_core #(.DECADE(DECADE)) u_core (
    .clk(clk), .clear(clear), .load_n(load_n), .preset(preset),
    .inc(up_rise), .dec(dn_rise), .cnt(cnt));

  term_count #(.DECADE(DECADE)) u_term (
    .cnt(cnt), .up_level(up_level), .dn_level(dn_level),
    .carry_n(carry_n), .borrow_n(borrow_n));

  assign count = cnt;

  // Carry releases on the very edge that wraps to zero
  p_carry_wrap_r9: assert property (@(posedge clk) disable iff (clear)
    !carry_n && up_rise && !dn_rise && load_n |=> !load_n || (cnt == '0 && carry_n));

  // Borrow releases on the very edge that wraps to the top value
  p_borrow_wrap_r10: assert property (@(posedge clk) disable iff (clear)
    !borrow_n && dn_rise && !up_rise && load_n |=> !load_n || (cnt == TOP && borrow_n));

  p_carry_top_r9: assert property (@(posedge clk) disable iff (clear)
    !carry_n |-> cnt == TOP);

  p_borrow_zero_r10: assert property (@(posedge clk) disable iff (clear)
    !borrow_n |-> cnt == '0);

  p_bcd_legal_r4: assert property (@(posedge clk) disable iff (clear)
    DECADE && load_n && $past(load_n) && $past(cnt) <= 4'd9 |-> cnt <= 4'd9);
endmodule

// File: tb/test_updn_counter.sv
module test_updn_counter;
  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       load_n = 1'b1;
  logic [3:0] preset = 4'd0;
  logic       pulse_up = 1'b1;
  logic       pulse_dn = 1'b1;
  logic [3:0] count_b, count_d;
  logic       carry_b, borrow_b, carry_d, borrow_d;

  always #10 clk = ~clk;

  updn_counter #(.DECADE(1'b0)) i_updn_counter (
    .clk(clk), .clear(clear), .load_n(load_n), .preset(preset),
    .pulse_up(pulse_up), .pulse_dn(pulse_dn),
    .count(count_b), .carry_n(carry_b), .borrow_n(borrow_b));

  updn_counter #(.DECADE(1'b1)) i_updn_counter_dec (
    .clk(clk), .clear(clear), .load_n(load_n), .preset(preset),
    .pulse_up(pulse_up), .pulse_dn(pulse_dn),
    .count(count_d), .carry_n(carry_d), .borrow_n(borrow_d));

  typedef struct {
    int    cb, cd;
    bit    cyb, bwb, cyd, bwd;
    string tag;
  } exp_t;

  exp_t q[$];
  event sample_ev;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  int   m_b = 0, m_d = 0;   // model counts
  bit   up_lvl = 1'b1, dn_lvl = 1'b1;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares to the outputs
  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "count bin", int'(count_b), e.cb);
      chk(e.tag, "count dec", int'(count_d), e.cd);
      chk(e.tag, "carry_n bin", int'(carry_b), int'(e.cyb));
      chk(e.tag, "borrow_n bin", int'(borrow_b), int'(e.bwb));
      chk(e.tag, "carry_n dec", int'(carry_d), int'(e.cyd));
      chk(e.tag, "borrow_n dec", int'(borrow_d), int'(e.bwd));
    end
  end

  task automatic expect_now(string tag);
    exp_t e;
    e.cb  = m_b;
    e.cd  = m_d;
    e.cyb = !(m_b == 15 && !up_lvl);
    e.bwb = !(m_b == 0 && !dn_lvl);
    e.cyd = !(m_d == 9 && !up_lvl);
    e.bwd = !(m_d == 0 && !dn_lvl);
    e.tag = tag;
    q.push_back(e);
    -> sample_ev;
    #1;
  endtask

  function automatic int bin_up(int v);  return (v + 1) % 16; endfunction
  function automatic int bin_dn(int v);  return (v + 15) % 16; endfunction
  function automatic int dec_up(int v);  return (v == 9) ? 0 : (v + 1) % 16; endfunction
  function automatic int dec_dn(int v);  return (v == 0) ? 9 : v - 1; endfunction

  // mode: 0 up, 1 down, 2 both
  task automatic pulse(int mode, string tag);
    @(negedge clk);
    if (mode != 1) pulse_up = 1'b0;
    if (mode != 0) pulse_dn = 1'b0;
    repeat (4) @(negedge clk);
    up_lvl = pulse_up;
    dn_lvl = pulse_dn;
    expect_now(tag);
    pulse_up = 1'b1;
    pulse_dn = 1'b1;
    repeat (3) @(negedge clk);
    up_lvl = 1'b1;
    dn_lvl = 1'b1;
    if (load_n) begin
      if (mode == 0) begin m_b = bin_up(m_b); m_d = dec_up(m_d); end
      if (mode == 1) begin m_b = bin_dn(m_b); m_d = dec_dn(m_d); end
    end
    expect_now(tag);
  endtask

  task automatic do_load(int v, string tag);
    @(negedge clk);
    #2;
    preset = 4'(v);
    load_n = 1'b0;
    #2;
    m_b = v;
    m_d = v;
    expect_now(tag);   // before any clk edge: asynchronous
  endtask

  task automatic end_load();
    @(negedge clk);
    load_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R8 reset");
    clear = 1'b0;
    repeat (5) @(negedge clk);
    expect_now("R8 release no step");

    pulse(0, "R1"); pulse(0, "R1"); pulse(0, "R1");
    pulse(1, "R2");
    pulse(1, "R2"); pulse(1, "R2");
    pulse(1, "R10 R3 R4 down wrap");
    pulse(0, "R9 R3 R4 up wrap");

    do_load(14, "R7 async load");
    end_load();
    pulse(0, "R5 up illegal");
    pulse(0, "R5 R3 up 15");
    do_load(12, "R7 load 12");
    end_load();
    pulse(1, "R5 down illegal");
    pulse(2, "R6 both");

    do_load(5, "R7 load 5");
    pulse(0, "R7 up ignored");
    pulse(1, "R7 dn ignored");
    @(negedge clk);
    #2;
    clear = 1'b1;
    #2;
    m_b = 0;
    m_d = 0;
    expect_now("R8 clear over load");
    @(negedge clk);
    load_n = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    repeat (5) @(negedge clk);
    expect_now("R8 after clear");
    pulse(0, "R1 after clear");

    #1;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule